// File: doc/BRIEF.md
# Floating-Point Operand Alignment Stage

This block is the first stage of a single-precision floating-point datapath. It takes two 32-bit operands and prepares them for an integer significand unit. In add/subtract mode it does four things:

- It subtracts the two 8-bit exponents once. The borrow of that subtraction identifies the operand with the smaller exponent.
- It routes that operand's 24-bit significand (hidden bit restored) to a logarithmic right shifter.
- It shifts that significand by the magnitude of the exponent difference.
- It reports the larger exponent.

The same difference decides whether the smaller significand would be shifted out entirely. In that case the shift is suppressed, the aligned significand is forced to zero, and the larger operand's significand carries the result alone.

In multiply mode the stage does no alignment. It passes both significands through unshifted and reports the biased sum of the exponents, ea + eb − 127. It does not treat NaN, infinity or denormal encodings specially. It passes signs through and does not act on them.

All outputs are registered. A result appears one clock after its input was accepted.

Top module: `fp_align_stage`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high. When `in_valid` is low, `out_valid` is low in the next cycle and every data output keeps its previous value.
- R2: After a synchronous reset with `rst_n` low, `out_valid`, `res_exp`, `big_sig`, `aligned_sig`, `swap`, `far`, `big_sign` and `small_sign` are all zero.
- R3: In add mode (`mul_mode`=0), `swap` is 1 exactly when the exponent field op_b[30:23] is greater than op_a[30:23]. Equal exponents give `swap`=0.
- R4: `big_sig` is the larger-exponent operand's significand, with the hidden 1 at bit 23 and the fraction (bits 22:0 of the operand) below it. A is chosen when `swap`=0 and B when `swap`=1.
- R5: In add mode, `aligned_sig` is the other operand's 24-bit significand, logically right-shifted by |ea − eb| when that magnitude is 23 or less.
- R6: In add mode, when |ea − eb| is 24 or more, `far` is 1 and `aligned_sig` is zero. Otherwise `far` is 0.
- R7: In add mode, `res_exp` is the larger of the two exponent fields, zero-extended to 10 bits.
- R8: In multiply mode (`mul_mode`=1), `res_exp` is ea + eb − 127 as a 10-bit two's-complement value. `big_sig` is A's significand and `aligned_sig` is B's unshifted significand. `swap` and `far` are both 0.
- R9: `big_sign` is bit 31 of the operand that supplied `big_sig`, and `small_sign` is bit 31 of the operand that supplied `aligned_sig`.
- R10: Equal exponents in add mode give a zero shift: `aligned_sig` equals B's full significand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on op_a/op_b are accepted this cycle |
| mul_mode | input | 1 | 1 = multiply conditioning, 0 = add/subtract alignment |
| op_a | input | 32 | Operand A, single-precision format |
| op_b | input | 32 | Operand B, single-precision format |
| out_valid | output | 1 | Registered result valid |
| res_exp | output | 10 | Result exponent (larger exponent, or biased sum) |
| big_sig | output | 24 | Unshifted significand of the larger operand (A in multiply mode) |
| aligned_sig | output | 24 | Shifted significand of the smaller operand (B in multiply mode) |
| swap | output | 1 | B had the larger exponent |
| far | output | 1 | Smaller significand entirely shifted out |
| big_sign | output | 1 | Sign of the operand in big_sig |
| small_sign | output | 1 | Sign of the operand in aligned_sig |

## Verification
The checker verifies these properties on every cycle against the previous cycle's inputs:

- the one-cycle valid latency and the holding of outputs while idle;
- the hidden bit in `big_sig`;
- that `far` forces `aligned_sig` to zero;
- that multiply mode never swaps or flags;
- the direction of `swap`;
- the larger-exponent result in add mode.

Only the directed scenarios show the remaining behaviour:

- the exact shifted values;
- the boundary at differences of 23 and 24;
- the negative biased exponent sum in multiply mode;
- the routing of the signs.

// File: rtl/fp_align_pkg.sv
// Package: shared constants and the mode encoding for the alignment stage.
// Assumes the single-precision layout: sign at bit 31, 8-bit exponent, 23-bit fraction.
package fp_align_pkg;
    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_MUL = 1'b1
    } align_mode_e;
endpackage

// File: rtl/fp_exp_compare.sv
// Module: fp_exp_compare
// One subtractor computes ea - eb. Its borrow marks B as the larger operand. The
// two's-complemented difference gives the shift magnitude, and the same magnitude
// flags a complete shift-out. Assumes biased, unsigned exponent fields.
module fp_exp_compare #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    output logic             borrow,
    output logic [EXP_W-1:0] diff_mag,
    output logic             shift_out
);
    logic [EXP_W:0] raw_diff;

    // Single subtraction: bit EXP_W is the borrow out.
    always_comb raw_diff = {1'b0, exp_a} - {1'b0, exp_b};

    // Borrow selects negation to get |ea - eb|; shift-out compares that magnitude.
    always_comb begin
        borrow    = raw_diff[EXP_W];
        diff_mag  = borrow ? (~raw_diff[EXP_W-1:0] + 1'b1) : raw_diff[EXP_W-1:0];
        shift_out = (diff_mag >= EXP_W'(SIG_W));
    end
endmodule

// File: rtl/fp_sig_router.sv
// Module: fp_sig_router
// Restores the hidden bit and steers the significands and signs. The larger
// operand goes to the unshifted path and the smaller to the shifter. Multiply
// mode pins A to the unshifted path and B to the shifter path. Assumes normal
// operands (hidden bit is always 1).
module fp_sig_router #(
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic              pick_b,
    output logic [SIG_W-1:0]  keep_sig,
    output logic [SIG_W-1:0]  move_sig,
    output logic              keep_sign,
    output logic              move_sign
);
    logic [SIG_W-1:0] sig_a;
    logic [SIG_W-1:0] sig_b;

    // Hidden-bit restoration on both operands.
    always_comb begin
        sig_a = {1'b1, frac_a};
        sig_b = {1'b1, frac_b};
    end

    // Borrow-controlled swap multiplexers.
    always_comb begin
        keep_sig  = pick_b ? sig_b  : sig_a;
        move_sig  = pick_b ? sig_a  : sig_b;
        keep_sign = pick_b ? sign_b : sign_a;
        move_sign = pick_b ? sign_a : sign_b;
    end
endmodule

// File: rtl/fp_right_shifter.sv
// Module: fp_right_shifter
// Logarithmic right shifter, one stage per bit of the shift amount, with a
// kill input that forces zero. Assumes the caller raises kill whenever the
// true shift is SIG_W or more.
module fp_right_shifter #(
    parameter int SIG_W = 24,
    localparam int SH_W = $clog2(SIG_W)
) (
    input  logic [SIG_W-1:0] din,
    input  logic [SH_W-1:0]  amt,
    input  logic             kill,
    output logic [SIG_W-1:0] dout
);
    logic [SIG_W-1:0] stage [SH_W+1];

    // Stage 0 is the unshifted input.
    always_comb stage[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        // Stage s shifts by 2**s when amt bit s is set.
        always_comb stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    // Suppression of alignment for an out-of-range difference.
    always_comb dout = kill ? '0 : stage[SH_W];
endmodule

// File: rtl/fp_align_stage.sv
// Module: fp_align_stage (top)
// Conditions two single-precision operands for a significand datapath.
// Add mode aligns the smaller operand to the larger one and reports the larger
// exponent. Multiply mode passes both significands through and reports the
// biased exponent sum. All outputs are registered with one cycle of latency,
// and they hold while in_valid is low. Special encodings are not decoded.
module fp_align_stage #(
    parameter int EXP_W  = fp_align_pkg::FP_EXP_W,
    parameter int FRAC_W = fp_align_pkg::FP_FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int SH_W  = $clog2(SIG_W),
    localparam int RES_W = EXP_W + 2,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mul_mode,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [RES_W-1:0]  res_exp,
    output logic [SIG_W-1:0]  big_sig,
    output logic [SIG_W-1:0]  aligned_sig,
    output logic              swap,
    output logic              far,
    output logic              big_sign,
    output logic              small_sign
);
    import fp_align_pkg::*;

    align_mode_e       mode;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic              borrow, shift_out;
    logic [EXP_W-1:0]  diff_mag;
    logic              pick_b, kill_shift;
    logic [SH_W-1:0]   shift_amt;
    logic [SIG_W-1:0]  keep_sig, move_sig, shifted_sig;
    logic              keep_sign, move_sign;
    logic [RES_W-1:0]  exp_next;

    // Field extraction and mode decode.
    always_comb begin
        mode  = align_mode_e'(mul_mode);
        exp_a = op_a[WORD_W-2 -: EXP_W];
        exp_b = op_b[WORD_W-2 -: EXP_W];
    end

    fp_exp_compare #(.EXP_W(EXP_W), .SIG_W(SIG_W)) cmp_i (
        .exp_a     (exp_a),
        .exp_b     (exp_b),
        .borrow    (borrow),
        .diff_mag  (diff_mag),
        .shift_out (shift_out)
    );

    // Multiply mode overrides the swap and the shift; add mode uses the compare.
    always_comb begin
        pick_b     = (mode == MODE_ADD) && borrow;
        kill_shift = (mode == MODE_ADD) && shift_out;
        shift_amt  = (mode == MODE_ADD) ? diff_mag[SH_W-1:0] : '0;
    end

    fp_sig_router #(.FRAC_W(FRAC_W)) route_i (
        .frac_a    (op_a[FRAC_W-1:0]),
        .frac_b    (op_b[FRAC_W-1:0]),
        .sign_a    (op_a[WORD_W-1]),
        .sign_b    (op_b[WORD_W-1]),
        .pick_b    (pick_b),
        .keep_sig  (keep_sig),
        .move_sig  (move_sig),
        .keep_sign (keep_sign),
        .move_sign (move_sign)
    );

    fp_right_shifter #(.SIG_W(SIG_W)) shift_i (
        .din  (move_sig),
        .amt  (shift_amt),
        .kill (kill_shift),
        .dout (shifted_sig)
    );

    // Result exponent: larger field for add, biased sum for multiply.
    always_comb begin
        if (mode == MODE_MUL)
            exp_next = RES_W'({2'b00, exp_a}) + RES_W'({2'b00, exp_b}) - RES_W'(BIAS);
        else
            exp_next = pick_b ? RES_W'(exp_b) : RES_W'(exp_a);
    end

    // Output register: capture on in_valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            res_exp     <= '0;
            big_sig     <= '0;
            aligned_sig <= '0;
            swap        <= 1'b0;
            far         <= 1'b0;
            big_sign    <= 1'b0;
            small_sign  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_exp     <= exp_next;
                big_sig     <= keep_sig;
                aligned_sig <= shifted_sig;
                swap        <= pick_b;
                far         <= kill_shift;
                big_sign    <= keep_sign;
                small_sign  <= move_sign;
            end
        end
    end
endmodule

// File: rtl/fp_align_chk.sv
// Module: fp_align_chk
// Checker bound to fp_align_stage. It relates each registered output to the
// inputs of the previous cycle. Assumes the synchronous active-low reset.
module fp_align_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1,
    localparam int RES_W = EXP_W + 2,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mul_mode,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [RES_W-1:0]  res_exp,
    input logic [SIG_W-1:0]  big_sig,
    input logic [SIG_W-1:0]  aligned_sig,
    input logic              swap,
    input logic              far,
    input logic              big_sign,
    input logic              small_sign
);
    logic [EXP_W-1:0] ea, eb, emax;

    // Exponent fields and their maximum, taken from the inputs.
    always_comb begin
        ea   = op_a[WORD_W-2 -: EXP_W];
        eb   = op_b[WORD_W-2 -: EXP_W];
        emax = (ea > eb) ? ea : eb;
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ($past(in_valid) && $past(rst_n)));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(big_sig) && $stable(aligned_sig) && $stable(res_exp)));

    // R4
    hidden_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> big_sig[SIG_W-1]);

    // R6
    far_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far |-> (aligned_sig == '0));

    // R8
    mul_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n && mul_mode) |-> (!swap && !far));

    // R3
    swap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n && !mul_mode) |-> (swap == $past(eb > ea)));

    // R7
    add_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n && !mul_mode) |-> (res_exp == RES_W'($past(emax))));
endmodule

bind fp_align_stage fp_align_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fp_align_stage_tb.sv
// Directed bench for fp_align_stage: one task per scenario, each checking its own results.
module fp_align_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mul_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [9:0]  res_exp;
    logic [23:0] big_sig, aligned_sig;
    logic        swap, far, big_sign, small_sign;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fp_align_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mul_mode(mul_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .res_exp(res_exp),
        .big_sig(big_sig), .aligned_sig(aligned_sig), .swap(swap), .far(far),
        .big_sign(big_sign), .small_sign(small_sign)
    );

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        return {s, 8'(e), f};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operand pair for one cycle, then sample at the following negedge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic m);
        @(negedge clk);
        op_a = a; op_b = b; mul_mode = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Applies a pair and compares every output with a model built from the requirements.
    task automatic run_case(input string tag, input logic [31:0] a, input logic [31:0] b, input logic m);
        int ea, eb, d;
        logic [23:0] sa, sb, e_big, e_al;
        logic e_swap, e_far, e_bs, e_ss;
        logic [9:0] e_exp;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        sa = {1'b1, a[22:0]}; sb = {1'b1, b[22:0]};
        if (m) begin
            e_exp = 10'(ea + eb - 127); e_big = sa; e_al = sb;
            e_swap = 1'b0; e_far = 1'b0; e_bs = a[31]; e_ss = b[31];
        end else begin
            e_swap = (eb > ea);
            d = e_swap ? eb - ea : ea - eb;
            e_exp = 10'(e_swap ? eb : ea);
            e_big = e_swap ? sb : sa;
            e_far = (d >= 24);
            e_al  = e_far ? 24'd0 : ((e_swap ? sa : sb) >> d);
            e_bs  = e_swap ? b[31] : a[31];
            e_ss  = e_swap ? a[31] : b[31];
        end
        apply(a, b, m);
        check({tag, " R1"}, "out_valid", 32'(out_valid), 32'd1);
        check({tag, m ? " R8" : " R7"}, "res_exp", 32'(res_exp), 32'(e_exp));
        check({tag, " R4"}, "big_sig", 32'(big_sig), 32'(e_big));
        check({tag, m ? " R8" : " R5"}, "aligned_sig", 32'(aligned_sig), 32'(e_al));
        check({tag, " R3"}, "swap", 32'(swap), 32'(e_swap));
        check({tag, " R6"}, "far", 32'(far), 32'(e_far));
        check({tag, " R9"}, "signs", 32'({big_sign, small_sign}), 32'({e_bs, e_ss}));
    endtask

    task automatic t_reset();
        check("R2", "out_valid", 32'(out_valid), 32'd0);
        check("R2", "res_exp", 32'(res_exp), 32'd0);
        check("R2", "sigs", 32'(big_sig | aligned_sig), 32'd0);
        check("R2", "flags", 32'({swap, far, big_sign, small_sign}), 32'd0);
    endtask

    task automatic t_a_larger();
        run_case("a_larger", mk(1'b0, 130, 23'h400000), mk(1'b1, 127, 23'h0F0F0F), 1'b0);
    endtask

    task automatic t_b_larger();
        run_case("b_larger", mk(1'b1, 100, 23'h123456), mk(1'b0, 110, 23'h7FFFFF), 1'b0);
    endtask

    task automatic t_equal();
        // R10: equal exponents, B's significand passes unshifted.
        run_case("equal_R10", mk(1'b0, 90, 23'h000001), mk(1'b1, 90, 23'h2AAAAA), 1'b0);
        check("R10", "aligned_full", 32'(aligned_sig), 32'h00AAAAAA);
    endtask

    task automatic t_edge23();
        run_case("diff23", mk(1'b0, 150, 23'h0), mk(1'b0, 127, 23'h0), 1'b0);
        check("R5", "hidden_only", 32'(aligned_sig), 32'd1);
    endtask

    task automatic t_edge24();
        run_case("diff24_R6", mk(1'b0, 103, 23'h7FFFFF), mk(1'b1, 127, 23'h7FFFFF), 1'b0);
    endtask

    task automatic t_huge();
        run_case("diff_huge_R6", mk(1'b1, 250, 23'h55555), mk(1'b0, 3, 23'h1), 1'b0);
    endtask

    task automatic t_mul();
        run_case("mul_R8", mk(1'b1, 140, 23'h100000), mk(1'b0, 200, 23'h000100), 1'b1);
        run_case("mul_neg_R8", mk(1'b0, 1, 23'h0), mk(1'b1, 1, 23'h7), 1'b1);
        check("R8", "neg_exp", 32'(res_exp), 32'd899);
    endtask

    task automatic t_hold();
        logic [9:0] e0; logic [23:0] b0, a0;
        run_case("hold_pre", mk(1'b0, 120, 23'h3), mk(1'b0, 118, 23'h4), 1'b0);
        e0 = res_exp; b0 = big_sig; a0 = aligned_sig;
        @(negedge clk);
        op_a = mk(1'b1, 5, 23'h7); op_b = mk(1'b1, 250, 23'h9);
        @(negedge clk);
        check("R1", "idle_valid", 32'(out_valid), 32'd0);
        check("R1", "idle_exp", 32'(res_exp), 32'(e0));
        check("R1", "idle_sigs", 32'(big_sig ^ aligned_sig), 32'(b0 ^ a0));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_a_larger();
        t_b_larger();
        t_equal();
        t_edge23();
        t_edge24();
        t_huge();
        t_mul();
        t_hold();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule